// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address stream for a short burst access. A load strobe captures a full external address: the bits above the beat field are held for the rest of the burst, and the low beat field becomes the burst's starting point. From then on, each cycle in which the active-low advance input is asserted moves to the next beat, and each cycle in which it is deasserted holds the current address. This gives a wait state without losing the position in the burst.

A static order select picks one of two wrap-around orderings. Linear order counts the low field upward modulo the burst length from the start value. Interleaved order forms the low field as the start value XOR a running beat index, which is the pattern some processors use for cache line fills. The burst never stops by itself: after the last beat it wraps back to the start value and keeps going until a new load arrives. With the default beat field width of 2, a burst is four beats.

Top module: `burst_addr_gen`

## Requirements
- R1: During and right after reset, `addr_o` is all zeros and `beat_o` is 0.
- R2: On an edge where `load_i` is 1, `addr_o` takes the value of `addr_i` and `beat_o` becomes 0, whatever the value of `adv_n_i`.
- R3: The bits of `addr_o` above the low `BEAT_W` bits change only on an edge where `load_i` is 1.
- R4: With `order_sel_i` = 0 (linear), a step edge (`load_i` = 0, `adv_n_i` = 0) sets the low `BEAT_W` bits of `addr_o` to their previous value plus 1, modulo 2^`BEAT_W`. For example, start 01 gives 01, 10, 11, 00.
- R5: With `order_sel_i` = 1 (interleaved), after a step the low `BEAT_W` bits of `addr_o` equal the start value XOR `beat_o`. For example, start 01 gives 01, 00, 11, 10.
- R6: After 2^`BEAT_W` steps, the low bits return to the start value, and further steps repeat the same sequence.
- R7: On an edge where `load_i` = 0 and `adv_n_i` = 1, `addr_o` and `beat_o` keep their values.
- R8: A load while a burst is in progress restarts the sequence from the new address, with `beat_o` = 0.
- R9: Each step increments `beat_o` by 1, modulo 2^`BEAT_W`.
- R10: Changing `order_sel_i` does not change `addr_o` by itself. The new order is applied from the next step onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Captures `addr_i` and starts a new burst |
| addr_i | input | ADDR_W | External address; its low BEAT_W bits are the start value |
| adv_n_i | input | 1 | Active-low advance: 0 steps to the next beat, 1 holds |
| order_sel_i | input | 1 | 0 selects linear order, 1 selects interleaved order |
| addr_o | output | ADDR_W | Current full address |
| beat_o | output | BEAT_W | Index of the current beat within the burst |

## Verification
The bench builds the block with a 12-bit address and the default 2-bit beat field. With a 12-bit address, random loads vary the held upper bits visibly, while the four-beat burst keeps every start value and every wrap point in both orders within a few cycles. Directed bursts cover all four start values in each order, running past the wrap. Random runs mix loads, steps and holds, and change the order only on load cycles. Separate directed sequences reload in the middle of a burst and toggle the order during holds.

// File: rtl/burst_pkg.sv
package burst_pkg;
   // Ordering of beats within one burst
   typedef enum logic {
      ORD_LINEAR = 1'b0,
      ORD_XOR    = 1'b1
   } order_e;
endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
   parameter int ADDR_W = 20,
   parameter int BEAT_W = 2,
   localparam int UP_W  = ADDR_W - BEAT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [UP_W-1:0]   upper_o,
   output logic [BEAT_W-1:0] start_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upper_o <= '0;
         start_o <= '0;
      end else if (load_i) begin
         upper_o <= addr_i[ADDR_W-1:BEAT_W];
         start_o <= addr_i[BEAT_W-1:0];
      end
   end

   // R3
   upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(upper_o));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   output logic [BEAT_W-1:0] beat_o,
   output logic [BEAT_W-1:0] next_beat_o
);
   localparam logic [BEAT_W-1:0] ONE  = BEAT_W'(1);
   localparam logic [BEAT_W-1:0] LAST = {BEAT_W{1'b1}};

   assign next_beat_o = beat_o + ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         beat_o <= '0;
      else if (load_i)
         beat_o <= '0;
      else if (step_i)
         beat_o <= next_beat_o;
   end

   // R9
   beat_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && beat_o == LAST) |=> (beat_o == '0));
   // R2
   beat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (beat_o == '0));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
   parameter int BEAT_W    = 2,
   parameter bit ALLOW_XOR = 1'b1
) (
   input  burst_pkg::order_e order_i,
   input  logic [BEAT_W-1:0] start_i,
   input  logic [BEAT_W-1:0] beat_i,
   output logic [BEAT_W-1:0] low_o
);
   logic [BEAT_W-1:0] lin_low;
   assign lin_low = start_i + beat_i;

   generate
      if (ALLOW_XOR) begin : g_both
         logic [BEAT_W-1:0] xor_low;
         assign xor_low = start_i ^ beat_i;
         always_comb begin
            unique case (order_i)
               burst_pkg::ORD_XOR: low_o = xor_low;
               default:            low_o = lin_low;
            endcase
         end
      end else begin : g_lin_only
         logic unused_order;
         assign unused_order = order_i;
         assign low_o = lin_low;
      end
   endgenerate
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
   parameter int ADDR_W    = 20,
   parameter int BEAT_W    = 2,
   parameter bit ALLOW_XOR = 1'b1,
   localparam int UP_W     = ADDR_W - BEAT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              adv_n_i,
   input  logic              order_sel_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BEAT_W-1:0] beat_o
);
   generate
      if (BEAT_W < 1 || BEAT_W > 8) begin : g_bad_beat
         $error("burst_addr_gen: BEAT_W out of range");
      end
      if (ADDR_W <= BEAT_W) begin : g_bad_addr
         $error("burst_addr_gen: ADDR_W must exceed BEAT_W");
      end
   endgenerate

   logic              step;
   logic [UP_W-1:0]   upper_q;
   logic [BEAT_W-1:0] start_q;
   logic [BEAT_W-1:0] next_beat;
   logic [BEAT_W-1:0] next_low;
   logic [BEAT_W-1:0] low_q;
   burst_pkg::order_e order;

   assign step  = !load_i && !adv_n_i;
   assign order = burst_pkg::order_e'(order_sel_i);

   burst_base_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_base (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .addr_i(addr_i),
      .upper_o(upper_q), .start_o(start_q)
   );

   burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(step),
      .beat_o(beat_o), .next_beat_o(next_beat)
   );

   burst_order_map #(.BEAT_W(BEAT_W), .ALLOW_XOR(ALLOW_XOR)) u_map (
      .order_i(order), .start_i(start_q), .beat_i(next_beat), .low_o(next_low)
   );

   // Low field is registered so an order change waits for the next step
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_q <= '0;
      else if (load_i)
         low_q <= addr_i[BEAT_W-1:0];
      else if (step)
         low_q <= next_low;
   end

   assign addr_o = {upper_q, low_q};

   // R2
   load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (addr_o == $past(addr_i)));
   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && adv_n_i) |=> ($stable(addr_o) && $stable(beat_o)));
   // R4
   linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !order_sel_i) |=>
         (addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + 1'b1)));
   // R5
   xor_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && order_sel_i && ALLOW_XOR) |=>
         ((addr_o[BEAT_W-1:0] ^ beat_o) == start_q));
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
   localparam int AW = 12;
   localparam int BW = 2;
   localparam int UW = AW - BW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          adv_n = 1'b1;
   logic          order = 1'b0;
   logic [AW-1:0] addr_o;
   logic [BW-1:0] beat_o;

   int n_chk = 0;
   int n_fail = 0;

   // model state
   logic [UW-1:0] m_up = '0;
   logic [BW-1:0] m_start = '0;
   logic [BW-1:0] m_beat = '0;
   logic [BW-1:0] m_low = '0;

   always #4 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW), .BEAT_W(BW)) u_dut (
      .clk(clk), .rst_n(rst_n), .load_i(load), .addr_i(addr),
      .adv_n_i(adv_n), .order_sel_i(order), .addr_o(addr_o), .beat_o(beat_o)
   );

   function automatic logic [BW-1:0] exp_low(input logic md,
                                             input logic [BW-1:0] st,
                                             input logic [BW-1:0] bt);
      return md ? (st ^ bt) : BW'(st + bt);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic drive(input logic ld, input logic [AW-1:0] a,
                        input logic advn, input logic md, input string tag);
      logic was_mid;
      @(negedge clk);
      load = ld; addr = a; adv_n = advn; order = md;
      was_mid = (m_beat != '0);
      @(posedge clk);
      if (ld) begin
         m_up = a[AW-1:BW]; m_start = a[BW-1:0]; m_beat = '0; m_low = a[BW-1:0];
      end else if (!advn) begin
         m_beat = m_beat + 1'b1;
         m_low  = exp_low(md, m_start, m_beat);
      end
      #2;
      if (tag != "") begin
         chk(tag, 32'(addr_o), 32'({m_up, m_low}));
      end else if (ld) begin
         chk(was_mid ? "R8 reload" : "R2 load", 32'(addr_o), 32'(a));
         chk("R2 beat clear", 32'(beat_o), 0);
      end else if (advn) begin
         chk("R7 hold", 32'(addr_o), 32'({m_up, m_low}));
      end else begin
         chk(md ? "R5 xor step" : "R4 linear step", 32'(addr_o[BW-1:0]), 32'(m_low));
         chk("R9 beat", 32'(beat_o), 32'(m_beat));
         if (m_beat == '0) chk("R6 wrap", 32'(addr_o[BW-1:0]), 32'(m_start));
      end
      chk("R3 upper", 32'(addr_o[AW-1:BW]), 32'(m_up));
   endtask

   initial begin
      #(8 * 50000);
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      #3;
      chk("R1 reset addr", 32'(addr_o), 0);
      chk("R1 reset beat", 32'(beat_o), 0);
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk("R1 after reset", 32'(addr_o), 0);

      // every start value, both orders, past the wrap
      for (int md = 0; md < 2; md++) begin
         for (int s = 0; s < 4; s++) begin
            drive(1'b1, AW'(12'h5A0 | s), 1'b0, md[0], "");
            for (int k = 0; k < 6; k++) drive(1'b0, '0, 1'b0, md[0], "");
         end
      end

      // specific sequences from the requirements
      drive(1'b1, 12'h001, 1'b1, 1'b1, "");
      drive(1'b0, '0, 1'b0, 1'b1, "");
      chk("R5 start01 beat1", 32'(addr_o[1:0]), 32'h0);
      drive(1'b0, '0, 1'b0, 1'b1, "");
      chk("R5 start01 beat2", 32'(addr_o[1:0]), 32'h3);
      drive(1'b0, '0, 1'b0, 1'b1, "");
      chk("R5 start01 beat3", 32'(addr_o[1:0]), 32'h2);

      // mid-burst reload then order toggle while holding
      drive(1'b1, 12'h3C2, 1'b0, 1'b0, "");
      drive(1'b0, '0, 1'b0, 1'b0, "");
      drive(1'b1, 12'h7F1, 1'b0, 1'b0, "");
      chk("R8 restart low", 32'(addr_o[1:0]), 32'h1);
      drive(1'b0, '0, 1'b0, 1'b0, "");
      drive(1'b0, '0, 1'b1, 1'b1, "R10 toggle hold");
      drive(1'b0, '0, 1'b1, 1'b0, "R10 toggle hold");
      drive(1'b0, '0, 1'b1, 1'b1, "R10 toggle hold");
      drive(1'b0, '0, 1'b0, 1'b1, "R10 next step");

      // random traffic; order changes only with a load
      begin
         logic md_r = 1'b0;
         for (int i = 0; i < 400; i++) begin
            logic ld_r;
            ld_r = ($urandom % 5) == 0;
            if (ld_r) md_r = $urandom % 2;
            drive(ld_r, AW'($urandom), ($urandom % 3) == 0, md_r, "");
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule